// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

The block holds three outgoing CAN messages, each with its own slot. A host fills a slot through a single load strobe. The strobe carries the base identifier, the extension bits, the extended-format and remote flags, a length code and eight data bytes, and it marks the slot as waiting. When the bit-level transmitter reports that it is free, the scheduler chooses one waiting slot. It then issues a one-cycle start pulse while presenting that slot's contents, and waits for the transmitter to report how the attempt ended.

Selection follows one of two orders. In identifier mode, the winner is the slot whose arbitration field would win on the bus. That field is compared bit by bit in the order it is sent. In arrival mode, the slot that has waited longest goes first. A failed attempt is either retried automatically or closed with a failure status, depending on the no-retry input. Each slot reports three flags: waiting, finished and finished-successfully.

The control is a three-state machine:
- ST_IDLE waits for a waiting slot while the transmitter is free. Taking the transition *launch* latches the chosen slot and moves to ST_SEND.
- ST_SEND drives the start pulse for one cycle. It always takes *handoff* to ST_WAIT.
- ST_WAIT holds until a result strobe arrives. The transition *settle* then returns to ST_IDLE.

Top module: `can_tx_sched`

## Requirements
- R1: After reset, all waiting, finished and success flags are 0 and tx_start is 0.
- R2: A load strobe to slot ld_idx (0..2) that is not waiting stores the message, sets its waiting flag and clears its finished and success flags. A load to a slot that is already waiting is ignored: the contents later sent are the earlier ones.
- R3: tx_start rises only one cycle after tx_ready was high in ST_IDLE while at least one slot was waiting. It is a one-cycle pulse, and tx_mbox and the tx fields carry the chosen slot's stored contents. With no slot waiting, no start is issued.
- R4: With fifo_mode=0, the waiting slot with the numerically lowest arbitration key is sent first. The key is 32 bits. A standard frame uses {base[10:0], rtr, 0, 18'b0, 0}. An extended frame uses {base[10:0], 1, 1, ext[17:0], rtr}.
- R5: With equal base identifiers, a standard data frame beats a standard remote frame, which beats any extended frame.
- R6: Slots with identical keys (fifo_mode=0) are served lowest slot index first.
- R7: With fifo_mode=1, waiting slots are served in the order their loads were accepted. A retried slot keeps its place.
- R8: A result with res_code=00 (success) clears the slot's waiting flag and sets its finished and success flags.
- R9: A result with res_code 01 (arbitration lost), 10 or 11 (error) and no_retry=0 leaves the slot waiting with its finished flag 0, and the slot competes again.
- R10: A failed result (code not 00) with no_retry=1 clears the waiting flag, sets finished to 1 and leaves success at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load strobe for one slot |
| ld_idx | input | 2 | Slot to load (0..2) |
| ld_base | input | 11 | Base identifier |
| ld_ext | input | 18 | Identifier extension bits |
| ld_ide | input | 1 | 1 = extended format |
| ld_rtr | input | 1 | 1 = remote frame |
| ld_dlc | input | 4 | Length code |
| ld_data | input | 64 | Data bytes |
| fifo_mode | input | 1 | 1 = arrival order, 0 = identifier priority |
| no_retry | input | 1 | 1 = one attempt per load |
| tx_ready | input | 1 | Transmitter is free |
| tx_start | output | 1 | One-cycle start of an attempt |
| tx_mbox | output | 2 | Slot being sent |
| tx_base | output | 11 | Base identifier of the sent slot |
| tx_ext | output | 18 | Extension bits of the sent slot |
| tx_ide | output | 1 | Format flag of the sent slot |
| tx_rtr | output | 1 | Remote flag of the sent slot |
| tx_dlc | output | 4 | Length code of the sent slot |
| tx_data | output | 64 | Data of the sent slot |
| res_valid | input | 1 | Result strobe, accepted in ST_WAIT |
| res_code | input | 2 | 00 success, 01 arbitration lost, 10/11 error |
| mb_pend | output | 3 | Waiting flag per slot |
| mb_done | output | 3 | Finished flag per slot |
| mb_ok | output | 3 | Finished-successfully flag per slot |

## Verification
Directed cases cover several fixed slot fillings:
- three standard identifiers in scrambled order, which tests numeric priority;
- one base identifier in standard data, standard remote and extended forms, which tests that the format and remote bits rank correctly rather than being ignored;
- two identical keys, which tests the index tie-break;
- a load order opposite to identifier order in arrival mode, which tests that the mode input really switches the ordering.

Repeated loads to a waiting slot show whether the ignore rule holds. Failure outcomes under both no-retry settings show retry versus closure.

Random rounds then mix modes, outcomes, slot subsets and small identifier ranges that force ties. Each sent slot and each status triple is compared against a bench model that tracks arrival stamps and bus keys.

// File: rtl/can_txs_pkg.sv
package can_txs_pkg;
    localparam int BASE_W = 11;
    localparam int EXT_W  = 18;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int KEY_W  = BASE_W + EXT_W + 3;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [EXT_W-1:0]  ext;
        logic              ide;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } mbox_t;

    typedef enum logic [1:0] {
        RES_OK  = 2'b00,
        RES_ARB = 2'b01,
        RES_ERR = 2'b10,
        RES_RSV = 2'b11
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } st_e;

    // Arbitration field in transmission order; lower value wins on the bus.
    function automatic logic [KEY_W-1:0] arb_key(input mbox_t m);
        if (m.ide)
            return {m.base, 1'b1, 1'b1, m.ext, m.rtr};
        else
            return {m.base, m.rtr, 1'b0, {EXT_W{1'b0}}, 1'b0};
    endfunction
endpackage

// File: rtl/can_txs_store.sv
module can_txs_store
    import can_txs_pkg::*;
#(
    parameter int NMB = 3,
    localparam int IDX_W = $clog2(NMB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  mbox_t            ld_msg,
    input  logic             complete,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [1:0]       res_code,
    input  logic             no_retry,
    output mbox_t            mbs   [NMB],
    output logic [NMB-1:0]   pend,
    output logic [NMB-1:0]   done,
    output logic [NMB-1:0]   ok,
    output logic [IDX_W-1:0] rank  [NMB]
);
    logic             accept;
    logic             succ;
    logic             leave;
    logic [IDX_W:0]   cnt;
    logic [IDX_W-1:0] new_rank;

    always_comb begin
        accept = ld_en && (int'(ld_idx) < NMB) && !pend[ld_idx];
        succ   = (res_code == RES_OK);
        leave  = complete && (succ || no_retry);
        cnt    = '0;
        for (int i = 0; i < NMB; i++) cnt = cnt + {{IDX_W{1'b0}}, pend[i]};
        new_rank = IDX_W'(cnt - {{IDX_W{1'b0}}, leave});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            done <= '0;
            ok   <= '0;
            for (int i = 0; i < NMB; i++) begin
                mbs[i]  <= '0;
                rank[i] <= '0;
            end
        end else begin
            if (accept) begin
                mbs[ld_idx]  <= ld_msg;
                pend[ld_idx] <= 1'b1;
                done[ld_idx] <= 1'b0;
                ok[ld_idx]   <= 1'b0;
                rank[ld_idx] <= new_rank;
            end
            if (leave) begin
                pend[cur_idx] <= 1'b0;
                done[cur_idx] <= 1'b1;
                ok[cur_idx]   <= succ;
                for (int i = 0; i < NMB; i++)
                    if (pend[i] && rank[i] > rank[cur_idx])
                        rank[i] <= rank[i] - 1'b1;
            end
        end
    end

    assert_success_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        complete && res_code == RES_OK |=>
        !pend[$past(cur_idx)] && done[$past(cur_idx)] && ok[$past(cur_idx)]);

    assert_retry_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        complete && res_code != RES_OK && !no_retry |=>
        pend[$past(cur_idx)] && !done[$past(cur_idx)]);

    assert_single_try_R10: assert property (@(posedge clk) disable iff (!rst_n)
        complete && res_code != RES_OK && no_retry |=>
        !pend[$past(cur_idx)] && done[$past(cur_idx)] && !ok[$past(cur_idx)]);

    assert_busy_load_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en && int'(ld_idx) < NMB && pend[ld_idx] |=>
        mbs[$past(ld_idx)] == $past(mbs[ld_idx]));
endmodule

// File: rtl/can_txs_pick.sv
module can_txs_pick
    import can_txs_pkg::*;
#(
    parameter int NMB = 3,
    localparam int IDX_W = $clog2(NMB)
) (
    input  mbox_t            mbs  [NMB],
    input  logic [NMB-1:0]   pend,
    input  logic [IDX_W-1:0] rank [NMB],
    input  logic             fifo_mode,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [KEY_W-1:0] keys [NMB];

    for (genvar g = 0; g < NMB; g++) begin : g_key
        assign keys[g] = arb_key(mbs[g]);
    end

    logic [KEY_W-1:0] best_key;
    logic [IDX_W-1:0] best_rank;

    always_comb begin
        any       = 1'b0;
        idx       = '0;
        best_key  = '1;
        best_rank = '1;
        for (int i = 0; i < NMB; i++) begin
            if (pend[i]) begin
                // strict compare keeps the lower index on ties
                if (!any || (fifo_mode ? (rank[i] < best_rank) : (keys[i] < best_key))) begin
                    any       = 1'b1;
                    idx       = IDX_W'(i);
                    best_key  = keys[i];
                    best_rank = rank[i];
                end
            end
        end
    end
endmodule

// File: rtl/can_txs_fsm.sv
module can_txs_fsm
    import can_txs_pkg::*;
#(
    parameter int NMB = 3,
    localparam int IDX_W = $clog2(NMB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_pend,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             tx_ready,
    input  logic             res_valid,
    output logic             tx_start,
    output logic             complete,
    output logic [IDX_W-1:0] cur_idx
);
    st_e              state, state_nx;
    logic [IDX_W-1:0] cur_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (any_pend && tx_ready) state_nx = ST_SEND;
            ST_SEND: state_nx = ST_WAIT;
            ST_WAIT: if (res_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && state_nx == ST_SEND) cur_q <= pick_idx;
        end
    end

    always_comb begin
        tx_start = 1'b0;
        complete = 1'b0;
        cur_idx  = cur_q;
        unique case (state)
            ST_IDLE: ;
            ST_SEND: tx_start = 1'b1;
            ST_WAIT: complete = res_valid;
            default: ;
        endcase
    end

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
    import can_txs_pkg::*;
#(
    parameter int NMB = 3,
    localparam int IDX_W = $clog2(NMB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [BASE_W-1:0] ld_base,
    input  logic [EXT_W-1:0]  ld_ext,
    input  logic              ld_ide,
    input  logic              ld_rtr,
    input  logic [DLC_W-1:0]  ld_dlc,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              fifo_mode,
    input  logic              no_retry,
    input  logic              tx_ready,
    output logic              tx_start,
    output logic [IDX_W-1:0]  tx_mbox,
    output logic [BASE_W-1:0] tx_base,
    output logic [EXT_W-1:0]  tx_ext,
    output logic              tx_ide,
    output logic              tx_rtr,
    output logic [DLC_W-1:0]  tx_dlc,
    output logic [DATA_W-1:0] tx_data,
    input  logic              res_valid,
    input  logic [1:0]        res_code,
    output logic [NMB-1:0]    mb_pend,
    output logic [NMB-1:0]    mb_done,
    output logic [NMB-1:0]    mb_ok
);
    mbox_t            ld_msg;
    mbox_t            mbs  [NMB];
    logic [IDX_W-1:0] rank [NMB];
    logic             any_pend;
    logic [IDX_W-1:0] pick_idx;
    logic             complete;
    logic [IDX_W-1:0] cur_idx;
    mbox_t            cur_msg;

    assign ld_msg = '{base: ld_base, ext: ld_ext, ide: ld_ide, rtr: ld_rtr,
                      dlc: ld_dlc, data: ld_data};

    can_txs_store #(.NMB(NMB)) u_store (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_msg(ld_msg),
        .complete(complete), .cur_idx(cur_idx), .res_code(res_code),
        .no_retry(no_retry), .mbs(mbs), .pend(mb_pend), .done(mb_done),
        .ok(mb_ok), .rank(rank)
    );

    can_txs_pick #(.NMB(NMB)) u_pick (
        .mbs(mbs), .pend(mb_pend), .rank(rank), .fifo_mode(fifo_mode),
        .any(any_pend), .idx(pick_idx)
    );

    can_txs_fsm #(.NMB(NMB)) u_fsm (
        .clk(clk), .rst_n(rst_n), .any_pend(any_pend), .pick_idx(pick_idx),
        .tx_ready(tx_ready), .res_valid(res_valid), .tx_start(tx_start),
        .complete(complete), .cur_idx(cur_idx)
    );

    assign cur_msg = mbs[cur_idx];
    assign tx_mbox = cur_idx;
    assign tx_base = cur_msg.base;
    assign tx_ext  = cur_msg.ext;
    assign tx_ide  = cur_msg.ide;
    assign tx_rtr  = cur_msg.rtr;
    assign tx_dlc  = cur_msg.dlc;
    assign tx_data = cur_msg.data;

    assert_start_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(tx_ready));

    assert_start_on_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> mb_pend[tx_mbox]);
endmodule

// File: tb/sim_can_tx_sched.sv
`timescale 1ns/1ps
module sim_can_tx_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_idx = '0;
    logic [10:0] ld_base = '0;
    logic [17:0] ld_ext = '0;
    logic        ld_ide = 1'b0, ld_rtr = 1'b0;
    logic [3:0]  ld_dlc = '0;
    logic [63:0] ld_data = '0;
    logic        fifo_mode = 1'b0, no_retry = 1'b0, tx_ready = 1'b0;
    logic        tx_start;
    logic [1:0]  tx_mbox;
    logic [10:0] tx_base;
    logic [17:0] tx_ext;
    logic        tx_ide, tx_rtr;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic        res_valid = 1'b0;
    logic [1:0]  res_code = '0;
    logic [2:0]  mb_pend, mb_done, mb_ok;

    always #10 clk = ~clk;

    can_tx_sched u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_base(ld_base),
        .ld_ext(ld_ext), .ld_ide(ld_ide), .ld_rtr(ld_rtr), .ld_dlc(ld_dlc),
        .ld_data(ld_data), .fifo_mode(fifo_mode), .no_retry(no_retry),
        .tx_ready(tx_ready), .tx_start(tx_start), .tx_mbox(tx_mbox),
        .tx_base(tx_base), .tx_ext(tx_ext), .tx_ide(tx_ide), .tx_rtr(tx_rtr),
        .tx_dlc(tx_dlc), .tx_data(tx_data), .res_valid(res_valid),
        .res_code(res_code), .mb_pend(mb_pend), .mb_done(mb_done), .mb_ok(mb_ok)
    );

    int nchk = 0, nerr = 0;
    logic [10:0] m_base [3];
    logic [17:0] m_ext  [3];
    logic        m_ide  [3], m_rtr [3];
    logic [3:0]  m_dlc  [3];
    logic [63:0] m_data [3];
    int          m_stamp[3];
    int          seq = 0;
    logic [2:0]  m_pend = '0, m_done = '0, m_ok = '0;

    task automatic chk(input bit c, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!c) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bkey(input int i);
        if (m_ide[i]) return {m_base[i], 1'b1, 1'b1, m_ext[i], m_rtr[i]};
        return {m_base[i], m_rtr[i], 1'b0, 18'd0, 1'b0};
    endfunction

    function automatic int expect_pick();
        int best = -1;
        for (int i = 0; i < 3; i++) begin
            if (m_pend[i]) begin
                if (best < 0) best = i;
                else if (fifo_mode && m_stamp[i] < m_stamp[best]) best = i;
                else if (!fifo_mode && bkey(i) < bkey(best)) best = i;
            end
        end
        return best;
    endfunction

    task automatic load(input int idx, input logic [10:0] b, input logic [17:0] e,
                        input logic ide, input logic rtr);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 2'(idx); ld_base = b; ld_ext = e; ld_ide = ide;
        ld_rtr = rtr; ld_dlc = 4'($urandom % 9); ld_data = {$urandom, $urandom};
        if (!m_pend[idx]) begin
            m_base[idx] = b; m_ext[idx] = e; m_ide[idx] = ide; m_rtr[idx] = rtr;
            m_dlc[idx] = ld_dlc; m_data[idx] = ld_data;
            m_pend[idx] = 1'b1; m_done[idx] = 1'b0; m_ok[idx] = 1'b0;
            m_stamp[idx] = seq; seq++;
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic chk_status(input string tag);
        chk(mb_pend == m_pend, tag, 64'(mb_pend), 64'(m_pend));
        chk(mb_done == m_done, tag, 64'(mb_done), 64'(m_done));
        chk(mb_ok == m_ok, tag, 64'(mb_ok), 64'(m_ok));
    endtask

    task automatic idle_no_start();
        bit seen = 0;
        tx_ready = 1'b1;
        repeat (5) begin
            @(negedge clk);
            if (tx_start) seen = 1;
        end
        tx_ready = 1'b0;
        chk(!seen, "R3 start without pending", 64'(seen), 64'd0);
    endtask

    task automatic serve(input logic [1:0] code, input string tag);
        int w = 0;
        int e;
        e = expect_pick();
        tx_ready = 1'b1;
        @(negedge clk);
        while (!tx_start && w < 20) begin
            @(negedge clk);
            w++;
        end
        tx_ready = 1'b0;
        chk(tx_start == 1'b1, "R3 start issued", 64'(tx_start), 64'd1);
        if (!tx_start || e < 0) return;
        chk(int'(tx_mbox) == e, tag, 64'(tx_mbox), 64'(e));
        chk(tx_base == m_base[e] && tx_ext == m_ext[e] && tx_ide == m_ide[e] &&
            tx_rtr == m_rtr[e], "R3 id fields", {tx_base, tx_ext, tx_ide, tx_rtr},
            {m_base[e], m_ext[e], m_ide[e], m_rtr[e]});
        chk(tx_dlc == m_dlc[e] && tx_data == m_data[e], "R3 payload", tx_data, m_data[e]);
        @(negedge clk);
        chk(!tx_start, "R3 single pulse", 64'(tx_start), 64'd0);
        res_valid = 1'b1; res_code = code;
        @(negedge clk);
        res_valid = 1'b0;
        if (code == 2'b00) begin
            m_pend[e] = 0; m_done[e] = 1; m_ok[e] = 1;
            chk_status("R8 success status");
        end else if (no_retry) begin
            m_pend[e] = 0; m_done[e] = 1; m_ok[e] = 0;
            chk_status("R10 single attempt status");
        end else begin
            chk_status("R9 retry status");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mb_pend == 0 && mb_done == 0 && mb_ok == 0, "R1 reset flags",
            {mb_pend, mb_done, mb_ok}, 64'd0);
        chk(!tx_start, "R1 reset start", 64'(tx_start), 64'd0);
        idle_no_start();

        // R5: same base, three forms
        fifo_mode = 0; no_retry = 0;
        load(0, 11'h100, 18'h0, 1, 0);
        load(1, 11'h100, 18'h0, 0, 1);
        load(2, 11'h100, 18'h0, 0, 0);
        chk_status("R2 load sets pending");
        serve(2'b00, "R5 std data first");
        serve(2'b00, "R5 std remote second");
        serve(2'b00, "R5 extended last");

        // R4: numeric order
        load(0, 11'h300, 18'h0, 0, 0);
        load(1, 11'h020, 18'h0, 0, 0);
        load(2, 11'h150, 18'h0, 0, 0);
        chk_status("R2 load clears done");
        serve(2'b00, "R4 lowest id");
        serve(2'b00, "R4 middle id");
        serve(2'b00, "R4 highest id");

        // R6: tie
        load(1, 11'h055, 18'h0, 0, 0);
        load(0, 11'h055, 18'h0, 0, 0);
        load(2, 11'h7FF, 18'h0, 0, 0);
        serve(2'b00, "R6 tie lowest index");
        serve(2'b00, "R6 tie second");
        serve(2'b00, "R6 tie last");

        // R7: arrival order opposite to id order
        fifo_mode = 1;
        load(2, 11'h7FF, 18'h0, 0, 0);
        load(0, 11'h400, 18'h0, 0, 0);
        load(1, 11'h001, 18'h0, 0, 0);
        serve(2'b00, "R7 oldest first");
        serve(2'b00, "R7 second oldest");
        serve(2'b00, "R7 newest");
        fifo_mode = 0;

        // R2: load into waiting slot ignored
        load(0, 11'h123, 18'h0, 0, 0);
        load(0, 11'h456, 18'h0, 0, 0);
        serve(2'b00, "R2 ignored reload");

        // R9 retry then success
        load(1, 11'h010, 18'h0, 0, 0);
        serve(2'b01, "R9 first attempt");
        serve(2'b00, "R9 retried slot");

        // R10 one attempt
        no_retry = 1;
        load(2, 11'h011, 18'h3, 1, 0);
        serve(2'b10, "R10 failed attempt");
        idle_no_start();
        no_retry = 0;

        for (int r = 0; r < 80; r++) begin
            fifo_mode = 1'($urandom % 2);
            no_retry  = 1'($urandom % 2);
            for (int k = 0; k < 3; k++) begin
                if ($urandom % 2 == 1)
                    load(int'($urandom % 3), 11'($urandom % 4), 18'($urandom % 3),
                         1'($urandom % 2), 1'($urandom % 2));
            end
            chk_status("R2 random load status");
            if (m_pend != 0) serve(2'($urandom % 4), fifo_mode ? "R7 random pick" : "R4 random pick");
            else idle_no_start();
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule